// File: doc/BRIEF.md
# Packed Byte Interleave and Halfword Pack Unit

This unit performs one of four lane permutations on two 32-bit operands and returns a registered 32-bit result. Two of the operations interleave bytes taken from the same half of both operands. The other two join one halfword from each operand. The lane order is chosen so that two passes transpose a 4x4 byte matrix held as four 32-bit rows. The first pass applies both interleaves to row pairs (0,1) and (2,3). The second pass applies both packs to the pairs of results. No memory access is needed.

A request is one cycle with `in_valid` high, an opcode and two operands. The result appears one clock later with `out_valid` high. When no request is presented, the result register keeps its last value.

Top module: `byte_permute_unit`

## Requirements
- R1: Opcode 2'b00 (high interleave). With A = a,b,c,d and B = e,f,g,h (most significant byte first), the result is a,e,b,f.
- R2: Opcode 2'b01 (low interleave). For the same operands, the result is c,g,d,h.
- R3: Opcode 2'b10 (high pack). The result is {A[31:16], B[31:16]}, with A's halfword in the upper position.
- R4: Opcode 2'b11 (low pack). The result is {A[15:0], B[15:0]}.
- R5: A request accepted at one rising edge appears on `out_result` after that edge, one cycle of latency.
- R6: `out_valid` equals the `in_valid` sampled at the previous rising edge.
- R7: While `rst_n` is low, `out_valid` and `out_result` are zero.
- R8: A cycle with `in_valid` low leaves `out_result` unchanged, whatever the opcode and operands are.
- R9: Two interleaves followed by two packs, fed with four row words, yield the byte transpose of the 4x4 matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | Operation select |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result strobe |
| out_result | output | 32 | Registered result |

## Verification
A wrong lane map shows as a misplaced byte or halfword in the very next result. The transpose sequence catches errors in lane order that single operations with symmetric data would hide. A broken clock enable shows as a result that changes on an idle cycle. A bad valid pipeline shows as a strobe that is one cycle early, one cycle late or missing. The bench checks a fixed vector for every opcode first, then random operands against a byte-slicing model.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  typedef enum logic [1:0] {
    OP_MRG_HI = 2'b00,
    OP_MRG_LO = 2'b01,
    OP_PCK_HI = 2'b10,
    OP_PCK_LO = 2'b11
  } bpu_op_e;
endpackage

// File: rtl/bpu_merge.sv
module bpu_merge #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    take_hi,
  input  logic [LANE_W*LANES-1:0] a,
  input  logic [LANE_W*LANES-1:0] b,
  output logic [LANE_W*LANES-1:0] y
);
  localparam int HALF = LANES / 2;

  for (genvar j = 0; j < HALF; j++) begin : g_lane
    logic [LANE_W-1:0] a_hi, a_lo, b_hi, b_lo;
    assign a_hi = a[(HALF+j)*LANE_W +: LANE_W];
    assign a_lo = a[j*LANE_W +: LANE_W];
    assign b_hi = b[(HALF+j)*LANE_W +: LANE_W];
    assign b_lo = b[j*LANE_W +: LANE_W];
    // A lanes take the odd output slots, B lanes the even ones
    assign y[(2*j+1)*LANE_W +: LANE_W] = take_hi ? a_hi : a_lo;
    assign y[(2*j)*LANE_W   +: LANE_W] = take_hi ? b_hi : b_lo;
  end
endmodule

// File: rtl/bpu_pack.sv
module bpu_pack #(
  parameter int WORD_W = 32
) (
  input  logic              take_hi,
  input  logic [WORD_W-1:0] a,
  input  logic [WORD_W-1:0] b,
  output logic [WORD_W-1:0] y
);
  localparam int HW = WORD_W / 2;

  always_comb begin
    if (take_hi) y = {a[WORD_W-1:HW], b[WORD_W-1:HW]};
    else         y = {a[HW-1:0], b[HW-1:0]};
  end
endmodule

// File: rtl/byte_permute_unit.sv
module byte_permute_unit #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [1:0]              in_op,
  input  logic [LANE_W*LANES-1:0] in_a,
  input  logic [LANE_W*LANES-1:0] in_b,
  output logic                    out_valid,
  output logic [LANE_W*LANES-1:0] out_result
);
  import bpu_pkg::*;
  localparam int W    = LANE_W * LANES;
  localparam int HALF = LANES / 2;
  localparam int HW   = W / 2;

  logic [W-1:0] merge_y, pack_y, sel_y;
  logic [W-1:0] result_d;
  logic         valid_d;
  bpu_op_e      op;

  assign op = bpu_op_e'(in_op);

  bpu_merge #(.LANE_W(LANE_W), .LANES(LANES)) u_merge (
    .take_hi(op == OP_MRG_HI), .a(in_a), .b(in_b), .y(merge_y));

  bpu_pack #(.WORD_W(W)) u_pack (
    .take_hi(op == OP_PCK_HI), .a(in_a), .b(in_b), .y(pack_y));

  assign sel_y = in_op[1] ? pack_y : merge_y;

  // next state: load only on a request (clock enable)
  always_comb begin
    valid_d  = in_valid;
    result_d = out_result;
    if (in_valid) result_d = sel_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid  <= valid_d;
      out_result <= result_d;
    end
  end

  // ---------------- assertions ----------------
  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> out_valid == $past(in_valid));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !$past(in_valid)) |-> $stable(out_result));

  p_merge_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && out_valid && $past(in_op) == 2'b00) |->
      (out_result[W-1 -: LANE_W] == $past(in_a[W-1 -: LANE_W]) &&
       out_result[W-1-LANE_W -: LANE_W] == $past(in_b[W-1 -: LANE_W])));

  p_merge_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && out_valid && $past(in_op) == 2'b01) |->
      (out_result[W-1 -: LANE_W] == $past(in_a[HALF*LANE_W-1 -: LANE_W]) &&
       out_result[W-1-LANE_W -: LANE_W] == $past(in_b[HALF*LANE_W-1 -: LANE_W])));

  p_pack_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && out_valid && $past(in_op) == 2'b10) |->
      (out_result[W-1:HW] == $past(in_a[W-1:HW]) &&
       out_result[HW-1:0] == $past(in_b[W-1:HW])));

  p_pack_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && out_valid && $past(in_op) == 2'b11) |->
      (out_result[W-1:HW] == $past(in_a[HW-1:0]) &&
       out_result[HW-1:0] == $past(in_b[HW-1:0])));
endmodule

// File: tb/tb_byte_permute_unit.sv
module tb_byte_permute_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'b00;
  logic [31:0] in_a = '0, in_b = '0;
  logic        out_valid;
  logic [31:0] out_result;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  byte_permute_unit dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_result(out_result));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bt(logic [31:0] w, int k); // k=0 is most significant
    return w[31-8*k -: 8];
  endfunction

  function automatic logic [31:0] model(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      2'b00:   return {bt(a,0), bt(b,0), bt(a,1), bt(b,1)};
      2'b01:   return {bt(a,2), bt(b,2), bt(a,3), bt(b,3)};
      2'b10:   return {bt(a,0), bt(a,1), bt(b,0), bt(b,1)};
      default: return {bt(a,2), bt(a,3), bt(b,2), bt(b,3)};
    endcase
  endfunction

  function automatic string tag(logic [1:0] op);
    case (op)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  // issue one request, return the result seen one cycle later
  task automatic issue(logic [1:0] op, logic [31:0] a, logic [31:0] b, output logic [31:0] res);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check("R5 valid", {31'b0, out_valid}, 32'd1);
    res = out_result;
  endtask

  task automatic t_reset();
    check("R7 valid", {31'b0, out_valid}, 32'd0);
    check("R7 result", out_result, 32'd0);
  endtask

  task automatic t_directed();
    logic [31:0] r;
    issue(2'b00, 32'hA1B2C3D4, 32'hE5F60718, r); check("R1", r, 32'hA1E5B2F6);
    issue(2'b01, 32'hA1B2C3D4, 32'hE5F60718, r); check("R2", r, 32'hC307D418);
    issue(2'b10, 32'h11223344, 32'h55667788, r); check("R3", r, 32'h11225566);
    issue(2'b11, 32'h11223344, 32'h55667788, r); check("R4", r, 32'h33447788);
  endtask

  task automatic t_random();
    logic [31:0] r, a, b;
    for (int i = 0; i < 200; i++) begin
      logic [1:0] op = 2'(i % 4);
      a = $urandom; b = $urandom;
      issue(op, a, b, r);
      check(tag(op), r, model(op, a, b));
    end
  endtask

  task automatic t_valid_pipe();
    @(negedge clk); in_valid = 1'b1; in_op = 2'b10; in_a = 32'h1; in_b = 32'h2;
    check("R6 before edge", {31'b0, out_valid}, 32'd0);
    @(negedge clk); in_valid = 1'b0;
    check("R6 after edge", {31'b0, out_valid}, 32'd1);
    @(negedge clk);
    check("R6 drop", {31'b0, out_valid}, 32'd0);
  endtask

  task automatic t_hold();
    logic [31:0] r;
    issue(2'b11, 32'hDEADBEEF, 32'hCAFEF00D, r);
    check("R8 load", r, 32'hBEEFF00D);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_op = 2'(i); in_a = $urandom; in_b = $urandom;
    end
    @(negedge clk);
    check("R8 hold", out_result, 32'hBEEFF00D);
  endtask

  task automatic t_transpose();
    logic [31:0] m [4];
    logic [31:0] t0, t1, t2, t3, o [4], exp;
    for (int i = 0; i < 4; i++) m[i] = $urandom;
    issue(2'b00, m[0], m[1], t0);
    issue(2'b00, m[2], m[3], t1);
    issue(2'b01, m[0], m[1], t2);
    issue(2'b01, m[2], m[3], t3);
    issue(2'b10, t0, t1, o[0]);
    issue(2'b11, t0, t1, o[1]);
    issue(2'b10, t2, t3, o[2]);
    issue(2'b11, t2, t3, o[3]);
    for (int c = 0; c < 4; c++) begin
      exp = {bt(m[0],c), bt(m[1],c), bt(m[2],c), bt(m[3],c)};
      check("R9 column", o[c], exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_directed();
    t_valid_pipe();
    t_hold();
    t_transpose();
    t_transpose();
    t_random();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule